// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out the address of the next instruction for a 32-bit RISC core. It takes the decoded instruction word, the two source register values and a small operation code from the decoder. From these it forms the next program counter: an absolute jump or call inside the current 256 MB region, a PC-relative unconditional branch, or a conditional branch on equality or on signed less-than. A call also asks for the return address to be written into the link register, which is general register 31.

The target arithmetic is combinational and reads the PC that the block holds itself. A single register holds the PC. It starts at zero and takes the computed value on each clock edge where the decoder marks the instruction as valid. Instruction fetch, the register file and exception handling sit outside the block.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_q` reads 0.
- R2: On a rising clock edge with `instr_valid` high, `pc_q` takes the value `next_pc` showed before the edge. With `instr_valid` low, `pc_q` keeps its value.
- R3: With `op_sel` = 1 (jump), `next_pc` = {`pc_q`[31:28], `instr`[31:6], 2'b00}.
- R4: With `op_sel` = 2 (call), `next_pc` follows the R3 target, `link_we` is 1 and `link_val` = `pc_q` + 4. `link_we` is 0 for every other `op_sel` value.
- R5: With `op_sel` = 3 (branch), `next_pc` = `pc_q` + 4 + off. Here off is `instr`[21:6] sign-extended to 32 bits with bits 1:0 cleared, so backward targets are reachable.
- R6: With `op_sel` = 4 (branch if equal), `next_pc` = `pc_q` + 4 + off when `src_a` equals `src_b`, and `pc_q` + 4 otherwise.
- R7: With `op_sel` = 5 (branch if less), `src_a` and `src_b` are compared as signed 32-bit values. `next_pc` = `pc_q` + 4 + off when `src_a` < `src_b`, and `pc_q` + 4 otherwise.
- R8: With `op_sel` = 0, 6 or 7, `next_pc` = `pc_q` + 4 and the instruction word and the operands have no effect.
- R9: `pc_q` stays word aligned: bits 1:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Current instruction is accepted; step the PC |
| op_sel | input | 3 | Operation: 0 none, 1 jump, 2 call, 3 branch, 4 branch-equal, 5 branch-less, 6/7 none |
| instr | input | 32 | Instruction word (imm26 in 31:6, imm16 in 21:6) |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Computed next program counter |
| link_we | output | 1 | Write the return address into register 31 |
| link_val | output | 32 | Return address, PC + 4 |

## Verification
The bound checker checks these rules on every cycle: the PC holds when no instruction is accepted and loads the computed value when one is, the PC stays word aligned, absolute targets keep the upper four PC bits, and the link write comes only with a call and carries PC + 4. The exact target of each operation can only be shown by the bench's scenarios. These include backward offsets, signed comparisons that an unsigned compare would get wrong, and equal operands. A backward branch from address zero wraps the PC into the top region, and a jump made there shows that the upper bits are kept.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int unsigned XW = 32,
  parameter int unsigned OPW = 3,
  parameter logic [XW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [OPW-1:0] op_sel,
  input  logic [XW-1:0] instr,
  input  logic [XW-1:0] src_a,
  input  logic [XW-1:0] src_b,
  output logic [XW-1:0] pc_q,
  output logic [XW-1:0] next_pc,
  output logic          link_we,
  output logic [XW-1:0] link_val
);
  localparam int unsigned IMMW = 16;
  localparam int unsigned REGN = 4;

  localparam logic [OPW-1:0] OP_JMP = OPW'(1);
  localparam logic [OPW-1:0] OP_CALL = OPW'(2);
  localparam logic [OPW-1:0] OP_BR = OPW'(3);
  localparam logic [OPW-1:0] OP_BEQ = OPW'(4);
  localparam logic [OPW-1:0] OP_BLT = OPW'(5);

  logic [XW-1:0] seq_pc, abs_tgt, rel_tgt, br_off;
  logic          take;

  assign seq_pc  = pc_q + XW'(4);
  assign abs_tgt = {pc_q[XW-1 -: REGN], instr[XW-1:6], 2'b00};
  assign br_off  = {{(XW-IMMW){instr[IMMW+5]}}, instr[IMMW+5:8], 2'b00};
  assign rel_tgt = seq_pc + br_off;

  always_comb begin
    unique case (op_sel)
      OP_BR:   take = 1'b1;
      OP_BEQ:  take = (src_a == src_b);
      OP_BLT:  take = ($signed(src_a) < $signed(src_b));
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    if (op_sel == OP_JMP || op_sel == OP_CALL) next_pc = abs_tgt;
    else if (take)                            next_pc = rel_tgt;
    else                                      next_pc = seq_pc;
  end

  assign link_we  = (op_sel == OP_CALL);
  assign link_val = seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pc_q <= RESET_PC;
    else if (instr_valid) pc_q <= next_pc;
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [2:0]  op_sel,
  input logic [31:0] pc_q,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [31:0] link_val
);
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc_q)); // R2
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> pc_q == $past(next_pc)); // R2
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00); // R9
  AST_ABS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1 || op_sel == 3'd2) |-> next_pc[31:28] == pc_q[31:28]); // R3
  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> op_sel == 3'd2); // R4
  AST_LINK_RET: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_val == pc_q + 32'd4); // R4
  AST_NONE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 || op_sel > 3'd5) |-> (next_pc == pc_q + 32'd4 && !link_we)); // R8
endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_sel(op_sel),
  .pc_q(pc_q), .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] instr = '0, src_a = '0, src_b = '0;
  logic [31:0] pc_q, next_pc, link_val;
  logic        link_we;

  int checks = 0, fails = 0;
  logic [31:0] mpc = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_sel(op_sel),
    .instr(instr), .src_a(src_a), .src_b(src_b), .pc_q(pc_q),
    .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [2:0] op,
      input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] off, seq;
    seq = pc + 32'd4;
    off = {{16{w[21]}}, w[21:6]} & 32'hFFFF_FFFC;
    case (op)
      3'd1, 3'd2: return {pc[31:28], w[31:6], 2'b00};
      3'd3: return seq + off;
      3'd4: return (a == b) ? seq + off : seq;
      3'd5: return ($signed(a) < $signed(b)) ? seq + off : seq;
      default: return seq;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [31:0] w,
                      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e;
    @(negedge clk);
    chk("R2", pc_q, mpc);
    chk("R9", {30'd0, pc_q[1:0]}, 32'd0);
    instr_valid = v; op_sel = op; instr = w; src_a = a; src_b = b;
    #1;
    e = ref_next(mpc, op, w, a, b);
    chk(req_of(op), next_pc, e);
    chk("R4", {31'd0, link_we}, {31'd0, op == 3'd2});
    if (op == 3'd2) chk("R4", link_val, mpc + 32'd4);
    if (v) mpc = e;
  endtask

  function automatic logic [31:0] bimm(input logic [15:0] imm);
    return {$urandom} & 32'hF800_003F | {10'd0, imm, 6'd0};
  endfunction

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1", pc_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pc_q, 32'd0);
    // R5: backward branch from 0 wraps into the top region
    step(1, 3'd3, bimm(16'hFFF8), 0, 0);
    // R3: jump keeps upper bits 0xF
    step(1, 3'd1, 32'h0000_1240, 0, 0);
    // R4: call in top region
    step(1, 3'd2, 32'hABCD_EF00, 0, 0);
    // R2: not valid, hold
    step(0, 3'd3, bimm(16'h0100), 0, 0);
    // R5: low bits of offset cleared
    step(1, 3'd3, bimm(16'h0013), 0, 0);
    // R6: equal and unequal
    step(1, 3'd4, bimm(16'h0040), 32'h55, 32'h55);
    step(1, 3'd4, bimm(16'h0040), 32'h55, 32'h56);
    // R7: signed vs unsigned disagreement
    step(1, 3'd5, bimm(16'hFF00), 32'hFFFF_FFFF, 32'd1);
    step(1, 3'd5, bimm(16'hFF00), 32'd1, 32'hFFFF_FFFF);
    step(1, 3'd5, bimm(16'hFF00), 32'd7, 32'd7);
    // R8: unused codes ignore instruction and operands
    step(1, 3'd0, 32'hFFFF_FFFF, 32'd3, 32'd3);
    step(1, 3'd6, 32'hFFFF_FFFF, 32'd1, 32'd2);
    step(1, 3'd7, 32'h1234_5678, 32'd9, 32'd9);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      step(($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)), $urandom, a, b);
    end
    @(negedge clk);
    chk("R2", pc_q, mpc);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule